// File: doc/BRIEF.md
# Per-Channel Lock and Unlock Flow Control

This block provides credit-free flow control for the guaranteed-service virtual channels of a router. Each virtual channel uses one reverse control wire. Each outgoing channel has a lockbox. The lockbox raises a link request only while the channel holds a flit and is unlocked. The lockbox shuts as soon as the link grants that flit. It reopens only when the buffer one hop downstream reports that it has drained. Because of this, at most one flit per channel is ever in flight, and a single channel's rate is limited to one flit per lock/unlock round trip. The full link rate is reached only when several channels run their round trips in overlap.

Each one-flit channel buffer also carries an unlockbox. When the buffer is read out, the unlockbox flips a level that tells the upstream router the space is free again. A stored setup table steers these levels backwards. It has one entry per input-side channel, and each entry names the local channel whose drain level is sent out on that input-side unlock wire. Each wire carries events by transition: every toggle counts as one unlock, whichever direction it goes.

Channels are numbered `c = port*NVC + vc`, and bit `c` of every per-channel vector belongs to channel `c`. With the defaults (5 ports, 7 channels each), the vectors are 35 bits wide.

Top module: `vc_lock_fc`

## Requirements
- R1: After reset, every lockbox is unlocked, every drain level and `unlock_out` bit is 0, every `proto_err` bit is 0, and every setup entry is invalid.
- R2: `lock_req[c]` is high, combinationally, exactly when channel `c` is unlocked and `has_flit[c]` is high.
- R3: A `link_grant[c]` seen while `lock_req[c]` is high locks channel `c` from the next cycle on. A grant while `lock_req[c]` is low has no effect: it causes no lock and no drain toggle.
- R4: An unlock event is a cycle in which `unlock_in[c]` differs from its value sampled at the previous clock edge. Both rising and falling edges count. A locked channel that sees an event is unlocked from the next cycle.
- R5: An unlock event on a channel that is already unlocked sets `proto_err[c]`. The flag stays set until reset.
- R6: A channel's drain level toggles exactly once, in the cycle after each accepted grant on that channel, and at no other time.
- R7: A write with `cfg_we` high and `cfg_valid` high stores, for entry (`cfg_port`,`cfg_vc`), the source channel (`cfg_src_port`,`cfg_src_vc`). From the next cycle, `unlock_out` of that entry follows the source channel's drain level.
- R8: An entry written with `cfg_valid` low drives its `unlock_out` bit constantly low.
- R9: A write in which any port field is at least NPORT, or any channel field is at least NVC, changes no entry.
- R10: Channels are independent. Locking or unlocking one channel leaves the lock state of every other channel unchanged, so different channels can be granted in consecutive cycles.
- R11: If a grant and an unlock event reach an unlocked channel in the same cycle, the channel ends up locked and `proto_err[c]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| has_flit | input | NPORT*NVC | Channel holds a flit ready to send |
| link_grant | input | NPORT*NVC | Link arbiter grant per channel |
| lock_req | output | NPORT*NVC | Link request per channel (unlocked and holding a flit) |
| unlock_in | input | NPORT*NVC | Toggle-signalled unlock wires arriving from downstream |
| unlock_out | output | NPORT*NVC | Toggle-signalled unlock wires sent upstream, one per input-side channel |
| proto_err | output | NPORT*NVC | Sticky flag: unlock event seen while unlocked |
| cfg_we | input | 1 | Setup-table write strobe |
| cfg_port | input | $clog2(NPORT) | Input port of the entry being written |
| cfg_vc | input | $clog2(NVC) | Channel of the entry being written |
| cfg_valid | input | 1 | Valid bit written into the entry |
| cfg_src_port | input | $clog2(NPORT) | Port of the channel whose drain level is forwarded |
| cfg_src_vc | input | $clog2(NVC) | Channel whose drain level is forwarded |

## Verification
The assertions check the per-channel lock mechanics on every cycle. They confirm that an accepted grant removes the request in the next cycle, and that an unlock event reopens a shut lockbox. They also confirm that a stray event raises the sticky error, and that the drain level moves only after an accepted grant. The bench scenarios are the only place the reverse steering is shown. They cover programming an entry, clearing it to a constant low, and rejecting out-of-range writes, including a write that would otherwise alias onto another entry. They also cover ignored grants, events in both directions, the grant-plus-event collision, and two channels of one port interleaved in consecutive cycles.

// File: rtl/vlfc_pkg.sv
package vlfc_pkg;

  typedef enum logic {
    LB_OPEN = 1'b0,
    LB_SHUT = 1'b1
  } lb_state_e;

  // flat channel number of a (port, vc) pair
  function automatic int chan_of(input int port, input int vc, input int nvc);
    return port * nvc + vc;
  endfunction

  // a (port, vc) pair names an existing channel
  function automatic logic pair_ok(input int port, input int vc,
                                   input int nport, input int nvc);
    return (port < nport) && (vc < nvc);
  endfunction

endpackage

// File: rtl/vlfc_lockbox.sv
module vlfc_lockbox
  import vlfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic has_flit,
  input  logic grant,
  input  logic unlock_wire,
  output logic req,
  output logic take,
  output logic locked,
  output logic unlock_evt,
  output logic err
);

  lb_state_e state;
  logic      wire_q;
  logic      err_q;

  assign unlock_evt = unlock_wire ^ wire_q;
  assign locked     = (state == LB_SHUT);
  assign req        = (state == LB_OPEN) && has_flit;
  assign take       = grant && req;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LB_OPEN;
      wire_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      wire_q <= unlock_wire;
      if (take) begin
        state <= LB_SHUT;
      end else if (unlock_evt) begin
        state <= LB_OPEN;
      end
      if (unlock_evt && (state == LB_OPEN)) begin
        err_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vlfc_unlockbox.sv
module vlfc_unlockbox (
  input  logic clk,
  input  logic rst_n,
  input  logic drain,
  output logic level
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
    end else if (drain) begin
      level <= ~level;
    end
  end

endmodule

// File: rtl/vlfc_rev_mux.sv
module vlfc_rev_mux
  import vlfc_pkg::*;
#(
  parameter int NPORT = 5,
  parameter int NVC   = 7,
  localparam int NCH  = NPORT * NVC,
  localparam int PW   = $clog2(NPORT),
  localparam int VW   = $clog2(NVC),
  localparam int CW   = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [PW-1:0]  cfg_port,
  input  logic [VW-1:0]  cfg_vc,
  input  logic           cfg_valid,
  input  logic [PW-1:0]  cfg_src_port,
  input  logic [VW-1:0]  cfg_src_vc,
  input  logic [NCH-1:0] drain_level,
  output logic [NCH-1:0] unlock_out
);

  logic          cfg_ok;
  logic [CW-1:0] wr_idx;
  logic [CW-1:0] src_idx;

  assign cfg_ok  = pair_ok(int'(cfg_port), int'(cfg_vc), NPORT, NVC) &&
                   pair_ok(int'(cfg_src_port), int'(cfg_src_vc), NPORT, NVC);
  assign wr_idx  = CW'(chan_of(int'(cfg_port), int'(cfg_vc), NVC));
  assign src_idx = CW'(chan_of(int'(cfg_src_port), int'(cfg_src_vc), NVC));

  logic [NCH-1:0] ent_valid;
  logic [CW-1:0]  ent_src [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ent
    logic hit;
    assign hit = cfg_we && cfg_ok && (wr_idx == CW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[c] <= 1'b0;
        ent_src[c]   <= '0;
      end else if (hit) begin
        ent_valid[c] <= cfg_valid;
        ent_src[c]   <= src_idx;
      end
    end

    assign unlock_out[c] = ent_valid[c] ? drain_level[ent_src[c]] : 1'b0;
  end

endmodule

// File: rtl/vc_lock_fc.sv
module vc_lock_fc
  import vlfc_pkg::*;
#(
  parameter int NPORT = 5,
  parameter int NVC   = 7,
  localparam int NCH  = NPORT * NVC,
  localparam int PW   = $clog2(NPORT),
  localparam int VW   = $clog2(NVC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] has_flit,
  input  logic [NCH-1:0] link_grant,
  output logic [NCH-1:0] lock_req,
  input  logic [NCH-1:0] unlock_in,
  output logic [NCH-1:0] unlock_out,
  output logic [NCH-1:0] proto_err,
  input  logic           cfg_we,
  input  logic [PW-1:0]  cfg_port,
  input  logic [VW-1:0]  cfg_vc,
  input  logic           cfg_valid,
  input  logic [PW-1:0]  cfg_src_port,
  input  logic [VW-1:0]  cfg_src_vc
);

  // internal events, named for the checker
  logic [NCH-1:0] take;
  logic [NCH-1:0] locked;
  logic [NCH-1:0] unlock_evt;
  logic [NCH-1:0] drain_level;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    vlfc_lockbox u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .has_flit   (has_flit[c]),
      .grant      (link_grant[c]),
      .unlock_wire(unlock_in[c]),
      .req        (lock_req[c]),
      .take       (take[c]),
      .locked     (locked[c]),
      .unlock_evt (unlock_evt[c]),
      .err        (proto_err[c])
    );

    vlfc_unlockbox u_unlock (
      .clk  (clk),
      .rst_n(rst_n),
      .drain(take[c]),
      .level(drain_level[c])
    );
  end

  vlfc_rev_mux #(
    .NPORT(NPORT),
    .NVC  (NVC)
  ) u_rev (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_port    (cfg_port),
    .cfg_vc      (cfg_vc),
    .cfg_valid   (cfg_valid),
    .cfg_src_port(cfg_src_port),
    .cfg_src_vc  (cfg_src_vc),
    .drain_level (drain_level),
    .unlock_out  (unlock_out)
  );

endmodule

// File: rtl/vlfc_chk.sv
module vlfc_chk #(
  parameter int NCH = 35
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] lock_req,
  input logic [NCH-1:0] take,
  input logic [NCH-1:0] locked,
  input logic [NCH-1:0] unlock_evt,
  input logic [NCH-1:0] drain_level,
  input logic [NCH-1:0] proto_err
);

  for (genvar c = 0; c < NCH; c++) begin : g_prop
    // R3
    grant_shuts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take[c] |=> !lock_req[c]);

    // R4
    event_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked[c] && unlock_evt[c]) |=> !locked[c]);

    // R10
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked[c] && !unlock_evt[c]) |=> locked[c]);

    // R5
    stray_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock_evt[c] && !locked[c]) |=> proto_err[c]);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err[c] |=> proto_err[c]);

    // R6
    drain_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take[c] |=> (drain_level[c] != $past(drain_level[c])));

    // R6
    drain_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take[c] |=> $stable(drain_level[c]));
  end

endmodule

bind vc_lock_fc vlfc_chk #(.NCH(NCH)) u_vlfc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock_req   (lock_req),
  .take       (take),
  .locked     (locked),
  .unlock_evt (unlock_evt),
  .drain_level(drain_level),
  .proto_err  (proto_err)
);

// File: tb/tb_vc_lock_fc.sv
`timescale 1ns/1ps
module tb_vc_lock_fc;

  localparam int NP  = 5;
  localparam int NV  = 7;
  localparam int NCH = NP * NV;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] has_flit = '0;
  logic [NCH-1:0] link_grant = '0;
  logic [NCH-1:0] unlock_in = '0;
  logic [NCH-1:0] lock_req, unlock_out, proto_err;
  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_port = '0, cfg_vc = '0, cfg_src_port = '0, cfg_src_vc = '0;
  logic           cfg_valid = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  vc_lock_fc #(.NPORT(NP), .NVC(NV)) dut (
    .clk(clk), .rst_n(rst_n), .has_flit(has_flit), .link_grant(link_grant),
    .lock_req(lock_req), .unlock_in(unlock_in), .unlock_out(unlock_out),
    .proto_err(proto_err), .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_vc(cfg_vc),
    .cfg_valid(cfg_valid), .cfg_src_port(cfg_src_port), .cfg_src_vc(cfg_src_vc)
  );

  function automatic int ch(input int p, input int v);
    return p * NV + v;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic cfg_write(input int p, input int v, input bit val, input int sp, input int sv);
    cfg_port = 3'(p); cfg_vc = 3'(v); cfg_valid = val;
    cfg_src_port = 3'(sp); cfg_src_vc = 3'(sv); cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic grant_once(input int c);
    link_grant[c] = 1'b1;
    tick();
    link_grant[c] = 1'b0;
  endtask

  task automatic t_reset();
    has_flit = '1;
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    check("R1 all unlocked", 64'(lock_req), 64'({NCH{1'b1}}));
    check("R1 unlock_out low", 64'(unlock_out), 64'h0);
    check("R1 proto_err low", 64'(proto_err), 64'h0);
    has_flit = '0;
    #1;
    check("R2 no flit no req", 64'(lock_req), 64'h0);
  endtask

  task automatic t_grant_lock();
    cfg_write(1, 1, 1'b1, 0, 0);
    check("R7 entry before drain", 64'(unlock_out[ch(1,1)]), 64'h0);
    has_flit[ch(0,0)] = 1'b1;
    #1;
    check("R2 req with flit", 64'(lock_req[ch(0,0)]), 64'h1);
    grant_once(ch(0,0));
    check("R3 locked after grant", 64'(lock_req[ch(0,0)]), 64'h0);
    check("R6 R7 drain forwarded", 64'(unlock_out[ch(1,1)]), 64'h1);
    tick();
    check("R6 single toggle", 64'(unlock_out[ch(1,1)]), 64'h1);
    check("R3 stays locked", 64'(lock_req[ch(0,0)]), 64'h0);
  endtask

  task automatic t_unlock();
    unlock_in[ch(0,0)] = 1'b1;
    #1;
    check("R4 not yet unlocked", 64'(lock_req[ch(0,0)]), 64'h0);
    tick();
    check("R4 unlocked on rise", 64'(lock_req[ch(0,0)]), 64'h1);
    check("R5 no error on legal unlock", 64'(proto_err[ch(0,0)]), 64'h0);
  endtask

  task automatic t_ignored_grant();
    cfg_write(3, 0, 1'b1, 2, 3);
    grant_once(ch(2,3));
    has_flit[ch(2,3)] = 1'b1;
    #1;
    check("R3 ignored grant no lock", 64'(lock_req[ch(2,3)]), 64'h1);
    check("R3 ignored grant no toggle", 64'(unlock_out[ch(3,0)]), 64'h0);
  endtask

  task automatic t_second();
    grant_once(ch(0,0));
    check("R6 toggles back", 64'(unlock_out[ch(1,1)]), 64'h0);
    check("R3 relocked", 64'(lock_req[ch(0,0)]), 64'h0);
    unlock_in[ch(0,0)] = 1'b0;
    tick();
    check("R4 unlocked on fall", 64'(lock_req[ch(0,0)]), 64'h1);
  endtask

  task automatic t_err();
    has_flit[ch(4,6)] = 1'b1;
    unlock_in[ch(4,6)] = 1'b1;
    tick();
    check("R5 stray event flagged", 64'(proto_err), 64'(1) << ch(4,6));
    check("R5 stays unlocked", 64'(lock_req[ch(4,6)]), 64'h1);
    repeat (2) tick();
    check("R5 flag sticky", 64'(proto_err[ch(4,6)]), 64'h1);
  endtask

  task automatic t_simul();
    has_flit[ch(1,5)] = 1'b1;
    unlock_in[ch(1,5)] = 1'b1;
    grant_once(ch(1,5));
    check("R11 grant wins lock", 64'(lock_req[ch(1,5)]), 64'h0);
    check("R11 error flagged", 64'(proto_err),
          (64'(1) << ch(4,6)) | (64'(1) << ch(1,5)));
  endtask

  task automatic t_invalid();
    grant_once(ch(0,0));
    check("R7 forwarded again", 64'(unlock_out[ch(1,1)]), 64'h1);
    cfg_write(1, 1, 1'b0, 0, 0);
    check("R8 invalid entry low", 64'(unlock_out[ch(1,1)]), 64'h0);
    unlock_in[ch(0,0)] = 1'b1;
    tick();
    check("R8 channel reopened", 64'(lock_req[ch(0,0)]), 64'h1);
  endtask

  task automatic t_range();
    has_flit[ch(1,0)] = 1'b1;
    grant_once(ch(1,0));
    cfg_write(0, 7, 1'b1, 0, 0);
    cfg_write(2, 2, 1'b1, 0, 7);
    cfg_write(5, 0, 1'b1, 0, 0);
    check("R9 out-of-range writes ignored", 64'(unlock_out), 64'h0);
  endtask

  task automatic t_interleave();
    cfg_write(0, 1, 1'b1, 3, 1);
    cfg_write(0, 2, 1'b1, 3, 2);
    has_flit[ch(3,1)] = 1'b1;
    has_flit[ch(3,2)] = 1'b1;
    grant_once(ch(3,1));
    check("R10 first locked", 64'(lock_req[ch(3,1)]), 64'h0);
    check("R10 neighbour still open", 64'(lock_req[ch(3,2)]), 64'h1);
    grant_once(ch(3,2));
    check("R10 both locked", 64'(lock_req[ch(3,2):ch(3,1)]), 64'h0);
    check("R10 both drains forwarded", 64'(unlock_out[ch(0,2):ch(0,1)]), 64'h3);
    unlock_in[ch(3,1)] = 1'b1;
    tick();
    check("R10 only first reopened", 64'(lock_req[ch(3,2):ch(3,1)]), 64'h1);
  endtask

  initial begin
    t_reset();
    t_grant_lock();
    t_unlock();
    t_ignored_grant();
    t_second();
    t_err();
    t_simul();
    t_invalid();
    t_range();
    t_interleave();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000ns;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule